// File: doc/BRIEF.md
# Segment Access Rights Checker

This block decides whether a single data access of 1, 2, 4 or 8 bytes may go through a cached segment descriptor. It sits beside the address generation path of a processor core. Each cycle it can take one request carrying three things: the operating mode, the cached descriptor attributes, and the access (offset, length code, direction). One clock later it returns a registered verdict.

The verdict has three parts. The first is a fault flag. The second is a fault class, which tells the exception logic whether a general protection, stack or segment-specific fault is due. The third is a pair of "fast path may be set" strobes, one for reads and one for writes. The descriptor cache ORs these strobes into its own sticky bits, so later accesses through the same segment can skip the full check.

The checker handles normal and expand-down data segments and code segments. The default-size bit selects the upper bound of an expand-down segment. In real mode only a plain limit test applies. In 64-bit mode every access passes.

Top module: `seg_access_checker`

## Requirements
- R1: A request on `req_valid` produces `chk_valid` exactly one clock later. Without a request, `chk_valid` is low and the other outputs hold their values. After reset all outputs are 0.
- R2: In mode 2 (64-bit), no access faults. `wr_fast_set` is set for a write (`acc_write`=1) and `rd_fast_set` for a read, and the other strobe is clear.
- R3: In mode 1 or 3 (protected), a descriptor with `dsc_valid`=0 faults with class 1 (general protection). This takes priority over every other check.
- R4: In protected mode, a valid descriptor with `dsc_present`=0 faults with class 3 (segment-specific). This takes priority over the type and limit checks.
- R5: In protected mode, a write to type 0, 1, 4 or 5 (read-only data) or to any type 8 to 15 (code) faults with class 3.
- R6: In protected mode, a read from type 8, 9, 12 or 13 (execute-only code) faults with class 3. Reads from all other types pass the type check.
- R7: For a segment that is not expand-down, with length L (1, 2, 4, 8 for `acc_len` 0 to 3), the access faults with class 3 in protected mode in either of two cases: offset > limit − L + 1, or L − 1 > limit. Neither expression wraps around.
- R8: For expand-down types 4 to 7, the upper bound U is 0xFFFFFFFF when `dsc_big`=1 and 0xFFFF when `dsc_big`=0. The access faults with class 3 in any of three cases: offset ≤ limit, offset > U, or U − offset < L − 1.
- R9: In mode 0 (real), only the R7 limit test applies, and type, valid and present bits are ignored. A failure faults with class 2 (stack) when `is_stack`=1 and class 1 otherwise.
- R10: In real and protected modes, the fast strobe for the access direction is set only when four conditions hold: there is no fault, the segment is not expand-down (real mode counts every segment as normal), the limit is at least 7, and the strobe matches the access direction. The strobe of the other direction stays clear.
- R11: A reported verdict has `fault_class` 0 exactly when `fault` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A check request is present this cycle |
| mode | input | 2 | 0 real, 1 protected, 2 64-bit, 3 treated as protected |
| dsc_valid | input | 1 | Descriptor cache entry is valid |
| dsc_present | input | 1 | Segment present bit |
| dsc_type | input | 4 | Descriptor type field |
| dsc_limit | input | OFF_W | Scaled (byte-granular) segment limit |
| dsc_big | input | 1 | Default-size bit; selects expand-down upper bound |
| acc_offset | input | OFF_W | Access offset within the segment |
| acc_len | input | 2 | Length code: 0→1, 1→2, 2→4, 3→8 bytes |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| is_stack | input | 1 | The segment is the stack segment |
| chk_valid | output | 1 | Verdict valid (one cycle after request) |
| fault | output | 1 | Access refused |
| fault_class | output | 2 | 0 none, 1 general protection, 2 stack, 3 segment-specific |
| rd_fast_set | output | 1 | Descriptor may mark reads as fast-path OK |
| wr_fast_set | output | 1 | Descriptor may mark writes as fast-path OK |

## Verification
The assertions check several rules on every cycle. They cover the one-cycle latency and the output hold, and the unconditional pass and direction strobe in 64-bit mode. They also check that an invalid descriptor in protected mode always yields a general protection fault, that fault and class agree, and that a fast strobe never goes with a fault or with the opposite direction.

The arithmetic edges need the bench's sweeps over boundary offsets and limits. These include the L − 1 > limit case for tiny limits, the 64 KB against 4 GB bound of expand-down segments, and the limit-of-7 threshold. The sweeps also show the full type permission table, the precedence of present over type over limit, and the stack/general split in real mode.

// File: rtl/segchk_pkg.sv
package segchk_pkg;
  typedef enum logic [1:0] {
    MD_REAL = 2'd0,
    MD_PROT = 2'd1,
    MD_LONG = 2'd2,
    MD_RSVD = 2'd3
  } op_mode_e;

  typedef enum logic [1:0] {
    FC_NONE  = 2'd0,
    FC_GP    = 2'd1,
    FC_STACK = 2'd2,
    FC_SEG   = 2'd3
  } fault_cls_e;

  localparam int unsigned LEN_CODE_W = 2;
  localparam int unsigned LM1_W      = 4;
  localparam int unsigned FAST_MIN_LIMIT = 7;
  localparam int unsigned SMALL_UB_W = 16;
endpackage

// File: rtl/segchk_perm.sv
module segchk_perm (
  input  logic [3:0] seg_type,
  output logic       rd_allowed,
  output logic       wr_allowed,
  output logic       expand_dn
);
  logic is_code;
  logic type_b1;

  always_comb begin
    is_code    = seg_type[3];
    type_b1    = seg_type[1];
    // data: bit1 = writable; code: bit1 = readable
    wr_allowed = !is_code && type_b1;
    rd_allowed = !is_code || type_b1;
    expand_dn  = !is_code && seg_type[2];
  end
endmodule

// File: rtl/segchk_limit.sv
module segchk_limit #(
  parameter int unsigned OFF_W = 32
) (
  input  logic [OFF_W-1:0]                 offset,
  input  logic [OFF_W-1:0]                 limit,
  input  logic [segchk_pkg::LM1_W-1:0]     len_m1,
  input  logic                             big,
  output logic                             up_fail,
  output logic                             dn_fail,
  output logic                             fast_limit_ok
);
  import segchk_pkg::*;
  localparam int unsigned EW = OFF_W + 1;

  logic [EW-1:0] off_e;
  logic [EW-1:0] lim_e;
  logic [EW-1:0] lm1_e;
  logic [EW-1:0] last_byte;
  logic [EW-1:0] top_bound;
  logic [EW-1:0] headroom;

  always_comb begin
    off_e     = {1'b0, offset};
    lim_e     = {1'b0, limit};
    lm1_e     = EW'(len_m1);
    // last byte touched, 33-bit so no wrap
    last_byte = off_e + lm1_e;
    up_fail   = last_byte > lim_e;
    top_bound = big ? {1'b0, {OFF_W{1'b1}}} : EW'({SMALL_UB_W{1'b1}});
    headroom  = top_bound - off_e;
    dn_fail   = (off_e <= lim_e) || (off_e > top_bound) || (headroom < lm1_e);
    fast_limit_ok = lim_e >= EW'(FAST_MIN_LIMIT);
  end
endmodule

// File: rtl/segchk_decide.sv
module segchk_decide (
  input  logic                    md_real,
  input  logic                    md_long,
  input  logic                    dsc_valid,
  input  logic                    dsc_present,
  input  logic                    is_stack,
  input  logic                    is_write,
  input  logic                    rd_allowed,
  input  logic                    wr_allowed,
  input  logic                    expand_dn,
  input  logic                    up_fail,
  input  logic                    dn_fail,
  input  logic                    fast_limit_ok,
  output logic                    fault_d,
  output segchk_pkg::fault_cls_e  cls_d,
  output logic                    rd_fast_d,
  output logic                    wr_fast_d
);
  import segchk_pkg::*;
  logic pass_fast;

  always_comb begin
    fault_d   = 1'b0;
    cls_d     = FC_NONE;
    pass_fast = 1'b0;
    if (md_long) begin
      pass_fast = 1'b1;
    end else if (md_real) begin
      if (up_fail) begin
        fault_d = 1'b1;
        cls_d   = is_stack ? FC_STACK : FC_GP;
      end else begin
        pass_fast = fast_limit_ok;
      end
    end else begin
      if (!dsc_valid) begin
        fault_d = 1'b1;
        cls_d   = FC_GP;
      end else if (!dsc_present) begin
        fault_d = 1'b1;
        cls_d   = FC_SEG;
      end else if (is_write ? !wr_allowed : !rd_allowed) begin
        fault_d = 1'b1;
        cls_d   = FC_SEG;
      end else if (expand_dn ? dn_fail : up_fail) begin
        fault_d = 1'b1;
        cls_d   = FC_SEG;
      end else begin
        pass_fast = !expand_dn && fast_limit_ok;
      end
    end
    rd_fast_d = pass_fast && !is_write;
    wr_fast_d = pass_fast && is_write;
  end
endmodule

// File: rtl/seg_access_checker.sv
module seg_access_checker #(
  parameter int unsigned OFF_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       mode,
  input  logic             dsc_valid,
  input  logic             dsc_present,
  input  logic [3:0]       dsc_type,
  input  logic [OFF_W-1:0] dsc_limit,
  input  logic             dsc_big,
  input  logic [OFF_W-1:0] acc_offset,
  input  logic [1:0]       acc_len,
  input  logic             acc_write,
  input  logic             is_stack,
  output logic             chk_valid,
  output logic             fault,
  output logic [1:0]       fault_class,
  output logic             rd_fast_set,
  output logic             wr_fast_set
);
  import segchk_pkg::*;

  logic [1:0] rst_pipe;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  logic [LM1_W-1:0] len_m1;
  logic rd_ok, wr_ok, ed;
  logic up_fail, dn_fail, lim_ge7;
  logic fault_d, rd_fast_d, wr_fast_d;
  fault_cls_e cls_d;
  logic md_real, md_long;

  always_comb begin
    len_m1  = LM1_W'((1 << acc_len) - 1);
    md_real = (mode == MD_REAL);
    md_long = (mode == MD_LONG);
  end

  segchk_perm u_perm (
    .seg_type   (dsc_type),
    .rd_allowed (rd_ok),
    .wr_allowed (wr_ok),
    .expand_dn  (ed)
  );

  segchk_limit #(.OFF_W(OFF_W)) u_limit (
    .offset        (acc_offset),
    .limit         (dsc_limit),
    .len_m1        (len_m1),
    .big           (dsc_big),
    .up_fail       (up_fail),
    .dn_fail       (dn_fail),
    .fast_limit_ok (lim_ge7)
  );

  segchk_decide u_decide (
    .md_real       (md_real),
    .md_long       (md_long),
    .dsc_valid     (dsc_valid),
    .dsc_present   (dsc_present),
    .is_stack      (is_stack),
    .is_write      (acc_write),
    .rd_allowed    (rd_ok),
    .wr_allowed    (wr_ok),
    .expand_dn     (ed),
    .up_fail       (up_fail),
    .dn_fail       (dn_fail),
    .fast_limit_ok (lim_ge7),
    .fault_d       (fault_d),
    .cls_d         (cls_d),
    .rd_fast_d     (rd_fast_d),
    .wr_fast_d     (wr_fast_d)
  );

  // next-state
  logic       vld_n, flt_n, rdf_n, wrf_n;
  logic [1:0] cls_n;
  always_comb begin
    vld_n = req_valid;
    flt_n = fault;
    cls_n = fault_class;
    rdf_n = rd_fast_set;
    wrf_n = wr_fast_set;
    if (req_valid) begin
      flt_n = fault_d;
      cls_n = cls_d;
      rdf_n = rd_fast_d;
      wrf_n = wr_fast_d;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      chk_valid   <= 1'b0;
      fault       <= 1'b0;
      fault_class <= 2'd0;
      rd_fast_set <= 1'b0;
      wr_fast_set <= 1'b0;
    end else begin
      chk_valid   <= vld_n;
      fault       <= flt_n;
      fault_class <= cls_n;
      rd_fast_set <= rdf_n;
      wr_fast_set <= wrf_n;
    end
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_s_n)
    req_valid |=> chk_valid);
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_s_n)
    !req_valid |=> (!chk_valid && $stable(fault) && $stable(fault_class)));
  p_long_pass_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (req_valid && mode == 2'd2) |=>
      (!fault && wr_fast_set == $past(acc_write) && rd_fast_set == !$past(acc_write)));
  p_invalid_gp_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (req_valid && mode[0] && !dsc_valid) |=> (fault && fault_class == 2'd1));
  p_fast_clean_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    chk_valid |-> ($onehot0({rd_fast_set, wr_fast_set}) && !(fault && (rd_fast_set || wr_fast_set))));
  p_class_agree_r11: assert property (@(posedge clk) disable iff (!rst_s_n)
    chk_valid |-> (fault == (fault_class != 2'd0)));
endmodule

// File: tb/sim_seg_access_checker.sv
module sim_seg_access_checker;
  logic clk = 1'b0;
  logic rst_n;
  logic req_valid;
  logic [1:0] mode;
  logic dsc_valid, dsc_present, dsc_big, acc_write, is_stack;
  logic [3:0] dsc_type;
  logic [31:0] dsc_limit, acc_offset;
  logic [1:0] acc_len;
  logic chk_valid, fault, rd_fast_set, wr_fast_set;
  logic [1:0] fault_class;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  seg_access_checker #(.OFF_W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
    .dsc_valid(dsc_valid), .dsc_present(dsc_present), .dsc_type(dsc_type),
    .dsc_limit(dsc_limit), .dsc_big(dsc_big), .acc_offset(acc_offset),
    .acc_len(acc_len), .acc_write(acc_write), .is_stack(is_stack),
    .chk_valid(chk_valid), .fault(fault), .fault_class(fault_class),
    .rd_fast_set(rd_fast_set), .wr_fast_set(wr_fast_set)
  );

  logic [31:0] lims [6] = '{32'd0, 32'd3, 32'd7, 32'd8, 32'h0000FFFF, 32'hFFFFFFF0};
  logic [31:0] offs [9] = '{32'd0, 32'd1, 32'd4, 32'd7, 32'd8, 32'h0000FFFC,
                           32'h0000FFFF, 32'h00010000, 32'hFFFFFFFB};

  // Expected verdict from the requirement text, in 64-bit signed arithmetic
  function automatic void model(input int md, input bit v, input bit p, input int t,
                                input longint lim, input longint off, input int lc,
                                input bit w, input bit db, input bit st,
                                output bit ef, output int ec, output bit er,
                                output bit ew, output string tag);
    longint len, ub;
    bit nf, df, ed, wok, rok, fastok;
    len = longint'(1) << lc;
    nf  = (len - 1 > lim) || (off > lim - len + 1);
    ub  = db ? 64'h00000000FFFFFFFF : 64'h000000000000FFFF;
    df  = (off <= lim) || (off > ub) || ((ub - off) < len - 1);
    ed  = (t >= 4 && t <= 7);
    wok = (t == 2 || t == 3 || t == 6 || t == 7);
    rok = !(t == 8 || t == 9 || t == 12 || t == 13);
    ef = 0; ec = 0; fastok = 0;
    if (md == 2) begin
      fastok = 1; tag = "R2";
    end else if (md == 0) begin
      tag = "R9";
      if (nf) begin ef = 1; ec = st ? 2 : 1; end
      else begin fastok = (lim >= 7); tag = "R10"; end
    end else begin
      if (!v)      begin ef = 1; ec = 1; tag = "R3"; end
      else if (!p) begin ef = 1; ec = 3; tag = "R4"; end
      else if (w && !wok)  begin ef = 1; ec = 3; tag = "R5"; end
      else if (!w && !rok) begin ef = 1; ec = 3; tag = "R6"; end
      else if (ed && df)   begin ef = 1; ec = 3; tag = "R8"; end
      else if (!ed && nf)  begin ef = 1; ec = 3; tag = "R7"; end
      else begin fastok = !ed && (lim >= 7); tag = ed ? "R8" : "R10"; end
    end
    er = fastok && !w;
    ew = fastok && w;
  endfunction

  task automatic apply(input int md, input bit v, input bit p, input int t,
                       input logic [31:0] lim, input logic [31:0] off, input int lc,
                       input bit w, input bit db, input bit st);
    bit ef, er, ew; int ec; string tag;
    model(md, v, p, t, longint'(lim), longint'(off), lc, w, db, st, ef, ec, er, ew, tag);
    req_valid = 1; mode = md[1:0]; dsc_valid = v; dsc_present = p; dsc_type = t[3:0];
    dsc_limit = lim; acc_offset = off; acc_len = lc[1:0]; acc_write = w;
    dsc_big = db; is_stack = st;
    @(posedge clk); @(negedge clk);
    vectors++;
    if (!chk_valid || fault !== ef || fault_class !== ec[1:0] ||
        rd_fast_set !== er || wr_fast_set !== ew) begin
      errors++;
      $display("FAIL %s (R1/R11 framing) md=%0d t=%0d lim=%h off=%h len=%0d w=%0d db=%0d: got v=%0b f=%0b c=%0d r=%0b w=%0b exp f=%0b c=%0d r=%0b w=%0b",
               tag, md, t, lim, off, lc, w, db, chk_valid, fault, fault_class,
               rd_fast_set, wr_fast_set, ef, ec, er, ew);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, got hang exp finish");
      summary();
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; mode = 0; dsc_valid = 0; dsc_present = 0;
    dsc_type = 0; dsc_limit = 0; dsc_big = 0; acc_offset = 0; acc_len = 0;
    acc_write = 0; is_stack = 0;
    repeat (3) @(negedge clk);
    vectors++;
    if (chk_valid || fault || fault_class != 0 || rd_fast_set || wr_fast_set) begin
      errors++;
      $display("FAIL R1 reset state: got %b%b%0d%b%b exp all zero",
               chk_valid, fault, fault_class, rd_fast_set, wr_fast_set);
    end
    rst_n = 1;
    repeat (4) @(negedge clk);

    // protected sweep: types, valid/present, lengths, direction, bound select
    for (int t = 0; t < 16; t++)
      for (int vp = 0; vp < 4; vp++)
        for (int li = 0; li < 6; li++)
          for (int oi = 0; oi < 9; oi++)
            for (int lc = 0; lc < 4; lc++)
              for (int w = 0; w < 2; w++)
                for (int db = 0; db < 2; db++)
                  apply(1, vp[1], vp[0], t, lims[li], offs[oi], lc, w[0], db[0], 0);

    // mode 3 behaves like protected
    for (int t = 0; t < 16; t++)
      for (int oi = 0; oi < 9; oi++)
        apply(3, 1, 1, t, 32'h0000FFFF, offs[oi], 2, t[0], 0, 0);

    // real mode: descriptor bits ignored, stack split (R9)
    for (int t = 0; t < 16; t += 5)
      for (int li = 0; li < 6; li++)
        for (int oi = 0; oi < 9; oi++)
          for (int lc = 0; lc < 4; lc++)
            for (int st = 0; st < 2; st++)
              apply(0, t[0], t[1], t, lims[li], offs[oi], lc, st[0], 0, st[0]);

    // 64-bit mode: all pass, even invalid / out of range (R2)
    for (int t = 0; t < 16; t++)
      for (int w = 0; w < 2; w++)
        apply(2, 0, 0, t, 32'd0, 32'hFFFFFFFB, 3, w[0], 0, 0);

    // idle: valid drops, verdict held (R1)
    apply(1, 1, 1, 2, 32'd100, 32'd200, 0, 1, 0, 0);
    req_valid = 0;
    @(posedge clk); @(negedge clk);
    vectors++;
    if (chk_valid || !fault || fault_class != 2'd3) begin
      errors++;
      $display("FAIL R1 idle hold: got v=%0b f=%0b c=%0d exp v=0 f=1 c=3",
               chk_valid, fault, fault_class);
    end

    done = 1;
    summary();
  end
endmodule